// File: doc/BRIEF.md
# General-Purpose Event Register Bank

This block holds a small bank of byte-wide event registers reached through one byte-addressed window of `LEN` locations. The window is cut at its midpoint. The lower half holds status bytes, which collect event bits and are cleared by writing ones. The upper half holds enable bytes, which software sets and reads like ordinary storage. A hardware event vector sets bits in the first status byte.

The block drives one interrupt request. It is high while the first status byte and the first enable byte share a set bit. Only that byte pair takes part in the interrupt. A power-management event contribution from elsewhere is expected to be ORed with `sci` outside the block. Reads are combinational. Any access outside the window is flagged for one cycle and has no other effect.

Top module: `gpe_event_bank`

## Requirements
- R1: For an address `a < LEN/2`, `rdata` shows status byte `a`. For `LEN/2 <= a < LEN`, `rdata` shows enable byte `a - LEN/2`. The read is combinational in the same cycle.
- R2: A write to a status byte clears every bit that is 1 in `wdata` and leaves every bit that is 0 in `wdata` unchanged, starting from the next cycle.
- R3: A write to an enable byte replaces its contents with `wdata`, starting from the next cycle. Enable bytes change by no other means except reset.
- R4: In any cycle where `evt` is nonzero, its set bits are ORed into status byte 0 on that clock edge. Status bytes 1 and above are never set by `evt`.
- R5: An access (`wr_en` or `rd_en`) at an address `>= LEN` makes `err` high for exactly the following cycle. While the address is out of range, `rdata` is 0. An out-of-range write changes no byte.
- R6: `sci` is high exactly when status byte 0 AND enable byte 0 is nonzero. Bytes 1 and above never affect it, and it follows a register change in the cycle after the clock edge that made the change.
- R7: While `rst_n` is low at a clock edge, all status and enable bytes clear to 0 and `err` clears, so `sci` is low after reset.
- R8: When a clearing write to status byte 0 and an event bit arrive in the same cycle, that event bit ends up set.
- R9: A read has no side effect. Reading a status byte twice returns the same value both times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| rd_en | input | 1 | Read strobe; used only for out-of-range detection |
| addr | input | ADDR_W | Byte address within the window |
| wdata | input | 8 | Write data: clear mask for status, new value for enable |
| rdata | output | 8 | Combinational read data of the selected byte, 0 when out of range |
| err | output | 1 | One-cycle flag after an out-of-range access |
| evt | input | 8 | Event bits ORed into status byte 0 |
| sci | output | 1 | Interrupt contribution of byte pair 0 |

## Verification
A wrong clear mask or a wrong decode leaves a status or enable byte holding the wrong bits. That value is visible at `rdata` on the next read of that address, one cycle after the faulty write. A corrupted byte 0 also shows on `sci` one cycle after the edge that corrupted it. This is tested by toggling enable bits against known status patterns. A lost event in a clear-and-event collision, or a write that leaks from an out-of-range address, shows on the readback that follows. A stuck or missing error flag shows on `err` in the cycle right after the access.

// File: rtl/gpe_bank_pkg.sv
// Shared types for the event register bank.
// Assumes a byte width of 8 and at most 16 bytes per half (LEN <= 32).
package gpe_bank_pkg;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;

    typedef logic [BYTE_W-1:0] gpe_byte_t;
    typedef logic [IDX_W-1:0]  gpe_idx_t;

    // Which half of the window an address falls into
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_BAD    = 2'd2
    } gpe_sel_e;
endpackage

// File: rtl/gpe_addr_decode.sv
// Splits the window at LEN/2 into status and enable halves and returns the
// byte index within the chosen half. Assumes LEN even, 2..32, and that ADDR_W
// is wide enough to hold LEN.
module gpe_addr_decode
    import gpe_bank_pkg::*;
#(
    parameter int LEN    = 8,
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output gpe_sel_e          sel,
    output gpe_idx_t          idx
);
    localparam int              HALF   = LEN / 2;
    localparam logic [ADDR_W-1:0] HALF_A = ADDR_W'(HALF);
    localparam logic [ADDR_W-1:0] LEN_A  = ADDR_W'(LEN);

    logic [ADDR_W-1:0] offset;

    // Classify the address and compute the offset inside its half
    always_comb begin
        offset = '0;
        if (addr < HALF_A) begin
            sel    = SEL_STATUS;
            offset = addr;
        end else if (addr < LEN_A) begin
            sel    = SEL_ENABLE;
            offset = addr - HALF_A;
        end else begin
            sel = SEL_BAD;
        end
    end

    assign idx = gpe_idx_t'(offset);
endmodule

// File: rtl/gpe_status_bank.sv
// Status bytes with write-one-to-clear semantics. Event bits are ORed into
// byte 0 after the clear, so an event beats a same-cycle clear.
module gpe_status_bank
    import gpe_bank_pkg::*;
#(
    parameter int HALF = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_en,
    input  gpe_idx_t  clr_idx,
    input  gpe_byte_t clr_mask,
    input  gpe_byte_t evt,
    output gpe_byte_t sts [HALF]
);
    for (genvar g = 0; g < HALF; g++) begin : g_byte
        logic      hit;
        gpe_byte_t set_bits;

        assign hit = clr_en && (clr_idx == gpe_idx_t'(g));

        if (g == 0) begin : g_evt
            assign set_bits = evt;
        end else begin : g_noevt
            assign set_bits = '0;
        end

        // Clear the written ones, then merge in any event bits
        always_ff @(posedge clk) begin
            if (!rst_n) sts[g] <= '0;
            else        sts[g] <= (sts[g] & ~(hit ? clr_mask : '0)) | set_bits;
        end
    end
endmodule

// File: rtl/gpe_enable_bank.sv
// Enable bytes: plain storage replaced by a write to its index.
module gpe_enable_bank
    import gpe_bank_pkg::*;
#(
    parameter int HALF = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  gpe_idx_t  wr_idx,
    input  gpe_byte_t wr_data,
    output gpe_byte_t en [HALF]
);
    for (genvar g = 0; g < HALF; g++) begin : g_byte
        // Load the byte when its index is written
        always_ff @(posedge clk) begin
            if (!rst_n)                                    en[g] <= '0;
            else if (wr_en && (wr_idx == gpe_idx_t'(g)))   en[g] <= wr_data;
        end
    end
endmodule

// File: rtl/gpe_event_bank.sv
// Top of the event register bank: decode, status and enable storage,
// combinational read mux, out-of-range flag and interrupt output.
// Assumes LEN even in 2..32; reads have no side effect.
module gpe_event_bank
    import gpe_bank_pkg::*;
#(
    parameter int LEN    = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              err,
    input  logic [7:0]        evt,
    output logic              sci
);
    localparam int HALF = LEN / 2;

    gpe_sel_e  sel;
    gpe_idx_t  idx;
    gpe_byte_t sts_arr [HALF];
    gpe_byte_t en_arr  [HALF];
    logic      sts_wr;
    logic      en_wr;
    logic      err_q;

    gpe_addr_decode #(.LEN(LEN), .ADDR_W(ADDR_W)) u_dec (
        .addr (addr),
        .sel  (sel),
        .idx  (idx)
    );

    assign sts_wr = wr_en && (sel == SEL_STATUS);
    assign en_wr  = wr_en && (sel == SEL_ENABLE);

    gpe_status_bank #(.HALF(HALF)) u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (sts_wr),
        .clr_idx  (idx),
        .clr_mask (wdata),
        .evt      (evt),
        .sts      (sts_arr)
    );

    gpe_enable_bank #(.HALF(HALF)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (en_wr),
        .wr_idx  (idx),
        .wr_data (wdata),
        .en      (en_arr)
    );

    // Select the addressed byte; zero when out of range
    always_comb begin
        rdata = '0;
        for (int i = 0; i < HALF; i++) begin
            if (idx == gpe_idx_t'(i)) begin
                if (sel == SEL_STATUS) rdata = sts_arr[i];
                if (sel == SEL_ENABLE) rdata = en_arr[i];
            end
        end
    end

    // Flag an out-of-range access for the following cycle
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (wr_en || rd_en) && (sel == SEL_BAD);
    end

    assign err = err_q;
    assign sci = |(sts_arr[0] & en_arr[0]);
endmodule

// File: rtl/gpe_event_bank_chk.sv
// Property checker for the event bank, attached by bind below.
module gpe_event_bank_chk #(
    parameter int LEN    = 8,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        wdata,
    input logic [7:0]        rdata,
    input logic              err,
    input logic [7:0]        evt,
    input logic              sci,
    input logic [7:0]        sts0,
    input logic [7:0]        en0
);
    localparam logic [ADDR_W-1:0] LEN_A  = ADDR_W'(LEN);
    localparam logic [ADDR_W-1:0] HALF_A = ADDR_W'(LEN / 2);

    // R2 and R8: clearing write to byte 0 keeps same-cycle event bits
    p_w1c_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == '0) |=> sts0 == (($past(sts0) & ~$past(wdata)) | $past(evt)));

    // R3: enable byte 0 only changes when written
    p_en_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == HALF_A) |=> $stable(en0));

    // R4: event bits appear in status byte 0
    p_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((sts0 & $past(evt)) == $past(evt)));

    // R5: out-of-range access raises the flag next cycle
    p_err_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && addr >= LEN_A) |=> err);

    // R5: flag only follows an out-of-range access
    p_err_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past((wr_en || rd_en) && addr >= LEN_A));

    // R5: out-of-range reads return zero
    p_rdata_bad_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= LEN_A) |-> rdata == '0);

    // R6: interrupt implies a shared bit in byte pair 0
    p_sci_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sci |-> ((sts0 & en0) != '0));

    // R7: reset clears state on the next edge
    p_rst_r7: assert property (@(posedge clk)
        !rst_n |=> (!err && sts0 == '0 && en0 == '0));
endmodule

bind gpe_event_bank gpe_event_bank_chk #(.LEN(LEN), .ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .err   (err),
    .evt   (evt),
    .sci   (sci),
    .sts0  (sts_arr[0]),
    .en0   (en_arr[0])
);

// File: tb/sim_gpe_event_bank.sv
`timescale 1ns/1ps
module sim_gpe_event_bank;
    localparam int LEN    = 8;
    localparam int ADDR_W = 6;
    localparam int HALF   = LEN / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = '0;
    logic [7:0]        evt = '0;
    logic [7:0]        rdata;
    logic              err;
    logic              sci;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [7:0] m_sts [HALF];
    logic [7:0] m_en  [HALF];
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    gpe_event_bank #(.LEN(LEN), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err(err), .evt(evt), .sci(sci)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(int a);
        if (a < HALF)     return m_sts[a];
        else if (a < LEN) return m_en[a - HALF];
        else              return 8'h00;
    endfunction

    task automatic step();
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; evt = '0; wdata = '0;
    endtask

    task automatic wr(int a, logic [7:0] d, logic [7:0] ev);
        @(negedge clk);
        wr_en = 1'b1; rd_en = 1'b0; addr = ADDR_W'(a); wdata = d; evt = ev;
        if (a < HALF)     m_sts[a] &= ~d;
        else if (a < LEN) m_en[a - HALF] = d;
        m_sts[0] |= ev;
    endtask

    task automatic pulse(logic [7:0] ev);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; evt = ev;
        m_sts[0] |= ev;
    endtask

    // Driver side of the scoreboard: push the expected read value
    task automatic rd(int a, string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; evt = '0; addr = ADDR_W'(a);
        exp_q.push_back(model_read(a));
        tag_q.push_back(tag);
    endtask

    function automatic logic [7:0] model_sci();
        return {7'd0, |(m_sts[0] & m_en[0])};
    endfunction

    // Monitor side: compare each read against the queued expectation
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_en && exp_q.size() > 0) begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < HALF; i++) begin m_sts[i] = '0; m_en[i] = '0; end
        repeat (3) @(negedge clk);
        check("R7 err after reset", {7'd0, err}, 8'h00);
        check("R7 sci after reset", {7'd0, sci}, 8'h00);
        rst_n = 1'b1;
        for (int a = 0; a < LEN; a++) rd(a, "R7 byte cleared");

        // R3 and R1: distinct enable values read back at their own addresses
        wr(HALF + 0, 8'h0F, 8'h00);
        wr(HALF + 1, 8'h3C, 8'h00);
        wr(HALF + 2, 8'h5A, 8'h00);
        wr(HALF + 3, 8'hC3, 8'h00);
        for (int i = 0; i < HALF; i++) rd(HALF + i, "R3 R1 enable readback");

        // R4: event goes only to status byte 0
        pulse(8'hA5);
        step();
        check("R6 sci on shared bit", {7'd0, sci}, model_sci());
        rd(0, "R4 event in byte 0");
        rd(1, "R4 byte 1 untouched");

        // R2: write-one-to-clear
        wr(0, 8'h05, 8'h00);
        step();
        check("R6 sci drops after clear", {7'd0, sci}, model_sci());
        rd(0, "R2 cleared bits");
        wr(1, 8'hFF, 8'h00);
        rd(1, "R2 clear of empty byte");

        // R6: toggling enable 0 against status A0
        wr(HALF, 8'h80, 8'h00);
        step();
        check("R6 sci on enable", {7'd0, sci}, model_sci());
        wr(HALF + 1, 8'hFF, 8'h00);
        wr(HALF, 8'h00, 8'h00);
        step();
        check("R6 byte 1 does not drive sci", {7'd0, sci}, model_sci());

        // R8: event beats simultaneous clear
        wr(0, 8'hFF, 8'h81);
        step();
        rd(0, "R8 event wins");

        // R9: reads leave state alone
        rd(0, "R9 first read");
        rd(0, "R9 second read");

        // R5: out-of-range write and read
        wr(LEN, 8'hFF, 8'h00);
        step();
        check("R5 err after bad write", {7'd0, err}, 8'h01);
        step();
        check("R5 err one cycle", {7'd0, err}, 8'h00);
        rd(LEN + 1, "R5 bad read is zero");
        step();
        check("R5 err after bad read", {7'd0, err}, 8'h01);
        wr((1 << ADDR_W) - 1, 8'h00, 8'h00);
        for (int a = 0; a < LEN; a++) rd(a, "R5 bad write no effect");

        // R7: reset in mid run
        pulse(8'hFF);
        @(negedge clk);
        rst_n = 1'b0; evt = '0; rd_en = 1'b0;
        for (int i = 0; i < HALF; i++) begin m_sts[i] = '0; m_en[i] = '0; end
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < LEN; a++) rd(a, "R7 cleared by reset");
        step();
        check("R7 sci after reset", {7'd0, sci}, 8'h00);

        repeat (3) step();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule